// File: doc/BRIEF.md
# Scroll Table Lookup Address Generator

This block sits in the background fetch path of a tile-based video controller. For each scanline and each 16-pixel column group it works out where the horizontal scroll word for plane A or plane B sits in video memory, and which slot of the vertical scroll memory applies. It also takes the scroll values that were fetched from those places and turns the screen position into a plane position. That position wraps at the configured plane width and height. Memory reads and pixel decoding happen elsewhere. The block only produces addresses and coordinates.

Each request carries the scanline, the column group, a plane select, both scroll modes, the horizontal scroll table base, the two plane size codes and the two fetched scroll values. Every output comes from a register. The result appears one clock after the request is accepted, and requests may arrive on every clock.

Top module: `scroll_fetch_gen`

## Requirements
- R1: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high, and the outputs then hold that request's results. Synchronous reset drives `out_valid` low.
- R2: `hs_addr` = `hs_base`×1024 + 4×entry + 2×`plane_b`, modulo 2^16. Each entry holds the plane A word at +0 and the plane B word at +2, and `plane_b` is 0 for A and 1 for B.
- R3: Horizontal mode 00 (whole screen) and mode 01 (an invalid code, handled as whole screen) both use entry 0 on every line.
- R4: Horizontal mode 10 (8-line bands) uses the scanline with its low three bits cleared as the entry.
- R5: Horizontal mode 11 (per line) uses the scanline itself as the entry.
- R6: `vs_index` equals `plane_b` when `vs_mode`=0 (whole screen). It equals 2×`col_idx` + `plane_b` when `vs_mode`=1 (per 16-pixel column).
- R7: `plane_x` = (16×`col_idx` − `hs_val`) modulo the plane width in pixels.
- R8: `plane_y` = (`line_num` + `vs_val`) modulo the plane height in pixels.
- R9: Each size code gives 32 cells (256 px) for 00, 64 cells (512 px) for 01 and 128 cells (1024 px) for 11. The invalid code 10 is handled as 32 cells.
- R10: If the decoded width × height exceeds 4096 cells (64×128, 128×64 or 128×128), the height is forced to 32 cells and the width is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| line_num | input | 9 | Screen scanline |
| col_idx | input | 6 | 16-pixel column group |
| plane_b | input | 1 | 0 = plane A, 1 = plane B |
| hs_mode | input | 2 | Horizontal scroll granularity code |
| vs_mode | input | 1 | Vertical scroll granularity |
| hs_base | input | 6 | Horizontal scroll table base, in 1 KiB units |
| size_w | input | 2 | Plane width code |
| size_h | input | 2 | Plane height code |
| hs_val | input | 10 | Fetched horizontal scroll value |
| vs_val | input | 10 | Fetched vertical scroll value |
| out_valid | output | 1 | Result strobe |
| hs_addr | output | 16 | Byte address of the horizontal scroll word |
| vs_index | output | 7 | Word index into vertical scroll memory |
| plane_x | output | 10 | Wrapped plane X in pixels |
| plane_y | output | 10 | Wrapped plane Y in pixels |

## Verification
The bench aims at the two invalid codes and at the oversize size combinations. A design that decodes horizontal mode 01 as banded or per-line gives addresses that move with the scanline. A design that passes size code 10 through as 64 cells wraps at 512 instead of 256. A design that skips the 4096-cell clamp returns Y values above 255. The bench also drives a subtraction that goes below zero at column 0 at every width, lines that land inside and on the edge of an 8-line band, and the last column in per-column vertical mode. A mistake in the borrow, the band mask or the index doubling shows up as a wrong address or a wrong coordinate. A randomized stream with back-to-back requests then checks the one-cycle alignment of each result with its request.

// File: rtl/scroll_fetch_pkg.sv
package scroll_fetch_pkg;
  typedef enum logic [1:0] {
    HSM_SCREEN = 2'b00,
    HSM_RSVD   = 2'b01,
    HSM_BAND   = 2'b10,
    HSM_LINE   = 2'b11
  } hs_mode_e;

  // log2 of the plane extent in units of 32 cells
  function automatic logic [1:0] size_shift(input logic [1:0] code);
    case (code)
      2'b01:   size_shift = 2'd1;
      2'b11:   size_shift = 2'd2;
      default: size_shift = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/scrl_size_dec.sv
module scrl_size_dec
  import scroll_fetch_pkg::*;
#(
  parameter int SCR_W = 10
) (
  input  logic [1:0]       size_w,
  input  logic [1:0]       size_h,
  output logic [SCR_W-1:0] w_mask,
  output logic [SCR_W-1:0] h_mask
);
  localparam int BASE_PIX = 256;

  logic [1:0] sh_w, sh_h, sh_h_eff;
  logic [2:0] sh_sum;

  always_comb begin
    sh_w   = size_shift(size_w);
    sh_h   = size_shift(size_h);
    sh_sum = {1'b0, sh_w} + {1'b0, sh_h};
    // product above 4096 cells once the combined shift reaches 3
    sh_h_eff = (sh_sum >= 3'd3) ? 2'd0 : sh_h;
    w_mask = SCR_W'((BASE_PIX << sh_w) - 1);
    h_mask = SCR_W'((BASE_PIX << sh_h_eff) - 1);
  end
endmodule

// File: rtl/scrl_hs_addr.sv
module scrl_hs_addr
  import scroll_fetch_pkg::*;
#(
  parameter int LINE_W = 9,
  parameter int BASE_W = 6,
  parameter int ADDR_W = BASE_W + 10
) (
  input  logic [LINE_W-1:0] line_num,
  input  logic              plane_b,
  input  logic [1:0]        hs_mode,
  input  logic [BASE_W-1:0] hs_base,
  output logic [ADDR_W-1:0] hs_addr
);
  localparam int BAND_BITS = 3;

  logic [LINE_W-1:0] entry;

  always_comb begin
    case (hs_mode_e'(hs_mode))
      HSM_BAND: entry = {line_num[LINE_W-1:BAND_BITS], {BAND_BITS{1'b0}}};
      HSM_LINE: entry = line_num;
      default:  entry = '0;
    endcase
    hs_addr = ADDR_W'({hs_base, 10'b0})
            + (ADDR_W'(entry) << 2)
            + (ADDR_W'(plane_b) << 1);
  end
endmodule

// File: rtl/scrl_wrap.sv
module scrl_wrap #(
  parameter int LINE_W = 9,
  parameter int COL_W  = 6,
  parameter int SCR_W  = 10
) (
  input  logic [COL_W-1:0]  col_idx,
  input  logic [LINE_W-1:0] line_num,
  input  logic [SCR_W-1:0]  hs_val,
  input  logic [SCR_W-1:0]  vs_val,
  input  logic [SCR_W-1:0]  w_mask,
  input  logic [SCR_W-1:0]  h_mask,
  output logic [SCR_W-1:0]  plane_x,
  output logic [SCR_W-1:0]  plane_y
);
  logic [SCR_W-1:0] scr_x;

  always_comb begin
    scr_x   = SCR_W'({col_idx, 4'b0000});
    plane_x = (scr_x - hs_val) & w_mask;
    plane_y = (SCR_W'(line_num) + vs_val) & h_mask;
  end
endmodule

// File: rtl/scroll_fetch_gen.sv
module scroll_fetch_gen #(
  parameter int LINE_W = 9,
  parameter int COL_W  = 6,
  parameter int BASE_W = 6,
  parameter int SCR_W  = 10,
  localparam int ADDR_W = BASE_W + 10,
  localparam int VS_W   = COL_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [LINE_W-1:0] line_num,
  input  logic [COL_W-1:0]  col_idx,
  input  logic              plane_b,
  input  logic [1:0]        hs_mode,
  input  logic              vs_mode,
  input  logic [BASE_W-1:0] hs_base,
  input  logic [1:0]        size_w,
  input  logic [1:0]        size_h,
  input  logic [SCR_W-1:0]  hs_val,
  input  logic [SCR_W-1:0]  vs_val,
  output logic              out_valid,
  output logic [ADDR_W-1:0] hs_addr,
  output logic [VS_W-1:0]   vs_index,
  output logic [SCR_W-1:0]  plane_x,
  output logic [SCR_W-1:0]  plane_y
);
  logic [SCR_W-1:0]  w_mask, h_mask, px_n, py_n;
  logic [ADDR_W-1:0] addr_n;
  logic [VS_W-1:0]   vsi_n;

  scrl_size_dec #(.SCR_W(SCR_W)) size_i (
    .size_w(size_w), .size_h(size_h), .w_mask(w_mask), .h_mask(h_mask)
  );

  scrl_hs_addr #(.LINE_W(LINE_W), .BASE_W(BASE_W), .ADDR_W(ADDR_W)) hsa_i (
    .line_num(line_num), .plane_b(plane_b), .hs_mode(hs_mode),
    .hs_base(hs_base), .hs_addr(addr_n)
  );

  scrl_wrap #(.LINE_W(LINE_W), .COL_W(COL_W), .SCR_W(SCR_W)) wrap_i (
    .col_idx(col_idx), .line_num(line_num), .hs_val(hs_val), .vs_val(vs_val),
    .w_mask(w_mask), .h_mask(h_mask), .plane_x(px_n), .plane_y(py_n)
  );

  always_comb begin
    vsi_n = vs_mode ? {col_idx, plane_b} : VS_W'(plane_b);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      hs_addr  <= addr_n;
      vs_index <= vsi_n;
      plane_x  <= px_n;
      plane_y  <= py_n;
    end
  end
endmodule

// File: rtl/scroll_fetch_chk.sv
module scroll_fetch_chk #(
  parameter int LINE_W = 9,
  parameter int COL_W  = 6,
  parameter int BASE_W = 6,
  parameter int SCR_W  = 10,
  parameter int ADDR_W = BASE_W + 10,
  parameter int VS_W   = COL_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              plane_b,
  input logic [1:0]        hs_mode,
  input logic              vs_mode,
  input logic [BASE_W-1:0] hs_base,
  input logic [1:0]        size_w,
  input logic [1:0]        size_h,
  input logic              out_valid,
  input logic [ADDR_W-1:0] hs_addr,
  input logic [VS_W-1:0]   vs_index,
  input logic [SCR_W-1:0]  plane_x,
  input logic [SCR_W-1:0]  plane_y
);
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_word_select_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> hs_addr[1:0] == {$past(plane_b), 1'b0});

  p_screen_entry_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !hs_mode[1]) |=>
      hs_addr == (ADDR_W'({$past(hs_base), 10'b0}) | ADDR_W'({$past(plane_b), 1'b0})));

  p_vs_whole_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !vs_mode) |=> vs_index == VS_W'($past(plane_b)));

  p_narrow_x_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !size_w[0]) |=> plane_x < SCR_W'(256));

  p_oversize_clamp_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_w == 2'b11 && size_h[0]) |=> plane_y < SCR_W'(256));
endmodule

bind scroll_fetch_gen scroll_fetch_chk #(
  .LINE_W(LINE_W), .COL_W(COL_W), .BASE_W(BASE_W), .SCR_W(SCR_W)
) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .plane_b(plane_b),
  .hs_mode(hs_mode), .vs_mode(vs_mode), .hs_base(hs_base),
  .size_w(size_w), .size_h(size_h), .out_valid(out_valid),
  .hs_addr(hs_addr), .vs_index(vs_index), .plane_x(plane_x), .plane_y(plane_y)
);

// File: tb/scroll_fetch_gen_tb.sv
module scroll_fetch_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [8:0] line_num = '0;
  logic [5:0] col_idx = '0;
  logic       plane_b = 1'b0;
  logic [1:0] hs_mode = '0;
  logic       vs_mode = 1'b0;
  logic [5:0] hs_base = '0;
  logic [1:0] size_w = '0;
  logic [1:0] size_h = '0;
  logic [9:0] hs_val = '0;
  logic [9:0] vs_val = '0;
  logic        out_valid;
  logic [15:0] hs_addr;
  logic [6:0]  vs_index;
  logic [9:0]  plane_x;
  logic [9:0]  plane_y;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    int    addr;
    int    vsi;
    int    px;
    int    py;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  scroll_fetch_gen dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .line_num(line_num),
    .col_idx(col_idx), .plane_b(plane_b), .hs_mode(hs_mode), .vs_mode(vs_mode),
    .hs_base(hs_base), .size_w(size_w), .size_h(size_h), .hs_val(hs_val),
    .vs_val(vs_val), .out_valid(out_valid), .hs_addr(hs_addr),
    .vs_index(vs_index), .plane_x(plane_x), .plane_y(plane_y)
  );

  task automatic check(string tag, string fld, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, fld, act, exp);
    end
  endtask

  function automatic int cells(int code);
    if (code == 1) return 64;
    if (code == 3) return 128;
    return 32;
  endfunction

  task automatic drive(int ln, int col, int pb, int hm, int vm, int base,
                       int sw, int sh, int hv, int vv, string tag);
    exp_t e;
    int ent, wc, hc, wp, hp;
    @(negedge clk);
    line_num = 9'(ln); col_idx = 6'(col); plane_b = 1'(pb);
    hs_mode = 2'(hm); vs_mode = 1'(vm); hs_base = 6'(base);
    size_w = 2'(sw); size_h = 2'(sh); hs_val = 10'(hv); vs_val = 10'(vv);
    in_valid = 1'b1;
    if (hm == 2)      ent = (ln / 8) * 8;
    else if (hm == 3) ent = ln;
    else              ent = 0;
    wc = cells(sw); hc = cells(sh);
    if (wc * hc > 4096) hc = 32;
    wp = wc * 8; hp = hc * 8;
    e.addr = (base * 1024 + ent * 4 + pb * 2) % 65536;
    e.vsi  = vm ? col * 2 + pb : pb;
    e.px   = (((col * 16 - hv) % wp) + wp) % wp;
    e.py   = (ln + vv) % hp;
    e.tag  = tag;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb.size() == 0) begin
        check("R1", "unexpected out_valid", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "hs_addr",  int'(hs_addr),  e.addr);
        check(e.tag, "vs_index", int'(vs_index), e.vsi);
        check(e.tag, "plane_x",  int'(plane_x),  e.px);
        check(e.tag, "plane_y",  int'(plane_y),  e.py);
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      check("watchdog", "timeout", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "out_valid after reset", int'(out_valid), 0);

    // horizontal table entry selection, base 0xB000
    drive(100, 0, 0, 0, 0, 6'h2C, 0, 0, 0, 0, "R3 whole-screen A");
    drive(100, 0, 1, 0, 0, 6'h2C, 0, 0, 0, 0, "R3 whole-screen B R2");
    drive(77,  3, 1, 1, 0, 6'h2C, 0, 0, 0, 0, "R3 invalid mode 01");
    drive(13,  0, 0, 2, 0, 6'h2C, 0, 0, 0, 0, "R4 band mid");
    drive(16,  0, 1, 2, 0, 6'h2C, 0, 0, 0, 0, "R4 band edge R2");
    drive(13,  0, 1, 3, 0, 6'h2C, 0, 0, 0, 0, "R5 per line");
    drive(511, 0, 0, 3, 0, 6'h3F, 0, 0, 0, 0, "R5 address wrap R2");
    // vertical index
    drive(0, 19, 1, 0, 1, 0, 0, 0, 0, 0, "R6 per column B");
    drive(0, 63, 0, 0, 1, 0, 0, 0, 0, 0, "R6 last column A");
    drive(0, 63, 1, 0, 0, 0, 0, 0, 0, 0, "R6 whole screen B");
    // X wrap at each width, borrow at column 0
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R7 R9 width 32");
    drive(0, 0, 0, 0, 0, 0, 1, 0, 1, 0, "R7 R9 width 64");
    drive(0, 0, 0, 0, 0, 0, 3, 0, 1, 0, "R7 R9 width 128");
    drive(0, 0, 0, 0, 0, 0, 2, 0, 1, 0, "R9 invalid width code");
    drive(0, 40, 0, 0, 0, 0, 1, 0, 100, 0, "R7 plain subtract");
    // Y wrap
    drive(250, 0, 0, 0, 0, 0, 0, 0, 0, 10, "R8 height 32");
    drive(250, 0, 0, 0, 0, 0, 0, 1, 0, 10, "R8 height 64");
    drive(250, 0, 0, 0, 0, 0, 0, 2, 0, 10, "R9 invalid height code");
    drive(300, 0, 0, 0, 0, 0, 0, 3, 0, 500, "R8 height 128");
    // oversize combinations
    drive(300, 0, 0, 0, 0, 0, 3, 1, 0, 0,   "R10 128x64");
    drive(300, 0, 0, 0, 0, 0, 1, 3, 0, 500, "R10 64x128");
    drive(300, 0, 0, 0, 0, 0, 3, 3, 0, 500, "R10 128x128");
    drive(300, 0, 0, 0, 0, 0, 1, 1, 0, 500, "R10 64x64 kept");
    drive(300, 0, 0, 0, 0, 0, 3, 0, 5, 500, "R10 128x32 kept");
    idle();
    @(negedge clk);
    check("R1", "out_valid idle", int'(out_valid), 0);

    // randomized back-to-back stream with gaps
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 4) == 0) idle();
      else drive($urandom_range(0, 511), $urandom_range(0, 63),
                 $urandom_range(0, 1), $urandom_range(0, 3),
                 $urandom_range(0, 1), $urandom_range(0, 63),
                 $urandom_range(0, 3), $urandom_range(0, 3),
                 $urandom_range(0, 1023), $urandom_range(0, 1023),
                 "R1 R2 R7 R8 random");
    end
    idle();
    repeat (3) @(negedge clk);
    check("R1", "results left unmatched", sb.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule